// File: doc/BRIEF.md
# Stop-Mode Wake-Up Sequencer

This block takes a processor core into a low-power stop state and brings it back out. On a stop request it latches four configuration bits: clock source, oscillator keep-alive, short-delay select and PLL use. While stopped it gates the oscillator enable and the PLL enable according to those bits. The oscillator and PLL sit outside the block. They appear here only as two enable outputs and one lock input.

On a wake request the block enters a recovery phase and runs two waits side by side. One is a stabilization delay counter whose length follows from the latched configuration. The other waits for the PLL to report lock again, and it applies only if the PLL was switched off during stop. The core-resume pulse is issued only when the later of the two has finished.

If lock never arrives, a timeout longer than any legal relock time ends the wait. The block then raises a sticky error flag and resumes the core anyway. All counting runs on a reference clock that stays alive through stop.

Top module: `stop_wake_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the block returns to run state. After that edge `oscEnable` and `pllEnable` are 1, `resumeCore` and `lockErr` are 0, and any recovery in progress is abandoned without a resume pulse.
- R2: In run state, `stopReq` high at a rising edge moves the block to stopped state and latches `useExtClk`, `oscKeep`, `shortDelay` and `pllEn`. Changes on those four inputs after that edge have no effect on the stop in progress.
- R3: In stopped state, `oscEnable` and `pllEnable` both equal the latched `oscKeep`. In run and recovery states both outputs are 1.
- R4: The stabilization delay D depends on the latched bits:
  - internal clock (`useExtClk`=0) with `oscKeep`=0: D is LONG_DELAY when `shortDelay`=0 and SHORT_DELAY when `shortDelay`=1.
  - internal clock with `oscKeep`=1: D is 0 and `shortDelay` is ignored.
  - external clock (`useExtClk`=1): D is SHORT_DELAY when `shortDelay`=1, 0 when `shortDelay`=0 and `oscKeep`=1, and LONG_DELAY when both are 0.
- R5: A lock wait applies only when the latched `pllEn`=1 and `oscKeep`=0. Count rising edges from the edge that accepts the wake request, that edge being edge 1. Let a be the edge after which `pllLock` is first seen high. With no lock wait, `resumeCore` is high after edge D+2. With a lock wait, it is high after edge max(D, a-1)+2.
- R6: If a lock wait applies and `pllLock` stays low, `resumeCore` and `lockErr` both go high after edge max(D, LOCK_TIMEOUT)+2.
- R7: `wakeReq` is acted on only in stopped state. In run state it produces no resume pulse and leaves both enables at 1. Holding it high during recovery does not change when the resume pulse occurs.
- R8: `resumeCore` is high for exactly one cycle for each completed recovery.
- R9: Once set, `lockErr` stays 1 in run state. It clears on the next stop entry or on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock, alive during stop |
| rst | input | 1 | Synchronous reset, active high |
| stopReq | input | 1 | Request to enter stop, honoured in run state |
| wakeReq | input | 1 | Request to leave stop, honoured in stopped state |
| useExtClk | input | 1 | Clock source: 0 internal oscillator, 1 external clock |
| oscKeep | input | 1 | 1 keeps the oscillator (and PLL) running during stop |
| shortDelay | input | 1 | 1 selects the short stop delay |
| pllEn | input | 1 | 1 when the core clock is derived from the PLL |
| pllLock | input | 1 | Lock indication from the PLL |
| oscEnable | output | 1 | Enable to the oscillator |
| pllEnable | output | 1 | Enable to the PLL |
| resumeCore | output | 1 | One-cycle pulse: the core may run again |
| lockErr | output | 1 | Sticky flag: recovery ended on lock timeout |

## Verification
Recovery latency is measured across the configuration table. The cases are internal clock with and without keep-alive, external clock with each combination of keep-alive and short delay, and the long against the short delay. These cases separate the delay lengths and show where the short-delay bit is ignored. The lock wait is tried twice with PLL relock enabled: once with a lock that arrives before the delay ends, so the delay dominates, and once with a lock that arrives after, so the lock dominates. A third run never delivers lock and must end at the timeout with the error flag set. Each stop also inverts all four configuration inputs after entry, wakes are issued both in run state and held through recovery, and a reset lands mid-recovery; any latching error or missing guard then shows up as a wrong latency or a stray resume pulse.

// File: rtl/swake_pkg.sv
package swake_pkg;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_STOPPED = 2'd1,
    ST_RECOVER = 2'd2
  } wakeState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCfg;  // capture configuration at stop entry
    logic clrCnt;   // zero the elapsed counter at wake acceptance
    logic incCnt;   // advance the elapsed counter during recovery
  } dpStrobe_t;

  typedef struct packed {
    logic useExtClk;
    logic oscKeep;
    logic shortDelay;
    logic pllEn;
  } stopCfg_t;

endpackage

// File: rtl/swake_dp.sv
module swake_dp
  import swake_pkg::*;
#(
  parameter int LONG_DELAY   = 1024,
  parameter int SHORT_DELAY  = 16,
  parameter int LOCK_TIMEOUT = 1200
) (
  input  logic      clk,
  input  logic      rst,
  input  dpStrobe_t strobe,
  input  stopCfg_t  cfgIn,
  input  logic      pllLock,
  output logic      heldKeep,
  output logic      dlyDone,
  output logic      lockDone,
  output logic      timeoutHit
);

  localparam int CNT_MAX = (LONG_DELAY > LOCK_TIMEOUT) ? LONG_DELAY : LOCK_TIMEOUT;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] LONG_V  = CW'(LONG_DELAY);
  localparam logic [CW-1:0] SHORT_V = CW'(SHORT_DELAY);
  localparam logic [CW-1:0] TOUT_V  = CW'(LOCK_TIMEOUT);
  localparam logic [CW-1:0] TOP_V   = CW'(CNT_MAX);

  stopCfg_t        cfgHeld;
  logic [CW-1:0]   elapsed;
  logic [CW-1:0]   dlyTarget;
  logic            needLock;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgHeld <= '0;
      elapsed <= '0;
    end else begin
      if (strobe.loadCfg) cfgHeld <= cfgIn;
      if (strobe.clrCnt) elapsed <= '0;
      else if (strobe.incCnt && elapsed != TOP_V) elapsed <= elapsed + 1'b1;
    end
  end

  // delay selection per clock source
  always_comb begin
    if (cfgHeld.useExtClk) begin
      if (cfgHeld.shortDelay)   dlyTarget = SHORT_V;
      else if (cfgHeld.oscKeep) dlyTarget = '0;
      else                      dlyTarget = LONG_V;
    end else begin
      if (cfgHeld.oscKeep)         dlyTarget = '0;
      else if (cfgHeld.shortDelay) dlyTarget = SHORT_V;
      else                         dlyTarget = LONG_V;
    end
  end

  assign needLock   = cfgHeld.pllEn & ~cfgHeld.oscKeep;
  assign dlyDone    = (elapsed >= dlyTarget);
  assign timeoutHit = needLock & ~pllLock & (elapsed >= TOUT_V);
  assign lockDone   = ~needLock | pllLock | timeoutHit;
  assign heldKeep   = cfgHeld.oscKeep;

  // R2: latched configuration only changes on a load strobe
  a_r2_cfg_held: assert property (@(posedge clk) disable iff (rst)
    !strobe.loadCfg |=> $stable(cfgHeld));

  // R4: the elapsed counter sticks at its top value instead of wrapping
  a_r4_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (strobe.incCnt && !strobe.clrCnt && elapsed == TOP_V) |=> elapsed == TOP_V);

endmodule

// File: rtl/swake_ctrl.sv
module swake_ctrl
  import swake_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      stopReq,
  input  logic      wakeReq,
  input  logic      heldKeep,
  input  logic      dlyDone,
  input  logic      lockDone,
  input  logic      timeoutHit,
  output dpStrobe_t strobe,
  output logic      oscEnable,
  output logic      pllEnable,
  output logic      resumeCore,
  output logic      lockErr
);

  wakeState_t state, nextState;
  logic       finish;

  assign finish = (state == ST_RECOVER) && dlyDone && lockDone;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_RUN:     if (stopReq) nextState = ST_STOPPED;
      ST_STOPPED: if (wakeReq) nextState = ST_RECOVER;
      ST_RECOVER: if (finish)  nextState = ST_RUN;
      default:    nextState = ST_RUN;
    endcase
  end

  always_comb begin
    strobe.loadCfg = (state == ST_RUN) && stopReq;
    strobe.clrCnt  = (state == ST_STOPPED) && wakeReq;
    strobe.incCnt  = (state == ST_RECOVER);
  end

  assign oscEnable = (state != ST_STOPPED) || heldKeep;
  assign pllEnable = (state != ST_STOPPED) || heldKeep;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_RUN;
      resumeCore <= 1'b0;
      lockErr    <= 1'b0;
    end else begin
      state      <= nextState;
      resumeCore <= finish;
      if (strobe.loadCfg)          lockErr <= 1'b0;
      else if (finish && timeoutHit) lockErr <= 1'b1;
    end
  end

  // R1: reset lands in run with no pulse and no error
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (state == ST_RUN && !resumeCore && !lockErr));

  // R2: a stop request in run is taken on the next edge
  a_r2_stop_entry: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && stopReq) |=> state == ST_STOPPED);

  // R7: without a stop request, run stays run whatever wakeReq does
  a_r7_run_holds: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && !stopReq) |=> (state == ST_RUN && !resumeCore));

  // R5: recovery persists while either wait is still open
  a_r5_wait_both: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RECOVER && !(dlyDone && lockDone)) |=> state == ST_RECOVER);

  // R6: a timed-out lock wait resumes with the error raised
  a_r6_timeout_flag: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RECOVER && dlyDone && timeoutHit) |=> (lockErr && resumeCore));

  // R8: the resume pulse lasts one cycle
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    resumeCore |=> !resumeCore);

endmodule

// File: rtl/stop_wake_seq.sv
module stop_wake_seq
  import swake_pkg::*;
#(
  parameter int LONG_DELAY   = 1024,
  parameter int SHORT_DELAY  = 16,
  parameter int LOCK_TIMEOUT = 1200
) (
  input  logic clk,
  input  logic rst,
  input  logic stopReq,
  input  logic wakeReq,
  input  logic useExtClk,
  input  logic oscKeep,
  input  logic shortDelay,
  input  logic pllEn,
  input  logic pllLock,
  output logic oscEnable,
  output logic pllEnable,
  output logic resumeCore,
  output logic lockErr
);

  dpStrobe_t strobe;
  stopCfg_t  cfgIn;
  logic      heldKeep, dlyDone, lockDone, timeoutHit;

  assign cfgIn = '{useExtClk: useExtClk, oscKeep: oscKeep,
                   shortDelay: shortDelay, pllEn: pllEn};

  swake_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .stopReq    (stopReq),
    .wakeReq    (wakeReq),
    .heldKeep   (heldKeep),
    .dlyDone    (dlyDone),
    .lockDone   (lockDone),
    .timeoutHit (timeoutHit),
    .strobe     (strobe),
    .oscEnable  (oscEnable),
    .pllEnable  (pllEnable),
    .resumeCore (resumeCore),
    .lockErr    (lockErr)
  );

  swake_dp #(
    .LONG_DELAY   (LONG_DELAY),
    .SHORT_DELAY  (SHORT_DELAY),
    .LOCK_TIMEOUT (LOCK_TIMEOUT)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .cfgIn      (cfgIn),
    .pllLock    (pllLock),
    .heldKeep   (heldKeep),
    .dlyDone    (dlyDone),
    .lockDone   (lockDone),
    .timeoutHit (timeoutHit)
  );

endmodule

// File: tb/tb_stop_wake_seq.sv
module tb_stop_wake_seq;

  localparam int LONG_D  = 1024;
  localparam int SHORT_D = 16;
  localparam int TOUT    = 1200;

  typedef struct {
    int    lat;
    int    err;
    string tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stopReq = 1'b0, wakeReq = 1'b0;
  logic useExtClk = 1'b0, oscKeep = 1'b0, shortDelay = 1'b0, pllEn = 1'b0;
  logic pllLock = 1'b0;
  logic oscEnable, pllEnable, resumeCore, lockErr;

  int nTests = 0;
  int nFail  = 0;
  int cyc    = 0;
  int wakeCyc = 0;
  bit resumeSeen = 1'b0;
  expItem_t expQ[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  stop_wake_seq #(.LONG_DELAY(LONG_D), .SHORT_DELAY(SHORT_D), .LOCK_TIMEOUT(TOUT)) dut (
    .clk(clk), .rst(rst), .stopReq(stopReq), .wakeReq(wakeReq),
    .useExtClk(useExtClk), .oscKeep(oscKeep), .shortDelay(shortDelay),
    .pllEn(pllEn), .pllLock(pllLock), .oscEnable(oscEnable),
    .pllEnable(pllEnable), .resumeCore(resumeCore), .lockErr(lockErr));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops an expected item for every resume pulse
  initial begin
    bit prevRes = 1'b0;
    forever begin
      @(negedge clk);
      if (resumeCore) begin
        if (prevRes) check(1'b0, "R8 pulse longer than one cycle", 1, 0);
        else if (expQ.size() == 0) check(1'b0, "R1/R7 unexpected resume", 1, 0);
        else begin
          expItem_t it;
          it = expQ.pop_front();
          check((cyc - wakeCyc + 1) == it.lat, {it.tag, " latency"}, cyc - wakeCyc + 1, it.lat);
          check(int'(lockErr) == it.err, {it.tag, " lockErr at resume"}, int'(lockErr), it.err);
          resumeSeen = 1'b1;
        end
      end
      prevRes = resumeCore;
    end
  end

  function automatic int delayOf(bit ext, bit keep, bit sh);
    if (ext) return sh ? SHORT_D : (keep ? 0 : LONG_D);
    return keep ? 0 : (sh ? SHORT_D : LONG_D);
  endfunction

  // lockAt: edge after which lock is driven high; 0 means never
  task automatic runCase(input bit ext, input bit keep, input bit sh, input bit pe,
                         input int lockAt, input bit holdWake, input string tag);
    expItem_t it;
    int d, k;
    bit need;
    need = pe && !keep;
    d = delayOf(ext, keep, sh);
    it.tag = tag;
    it.err = 0;
    if (!need) it.lat = d + 2;
    else if (lockAt > 0) it.lat = ((d > lockAt - 1) ? d : lockAt - 1) + 2;
    else begin
      it.lat = ((d > TOUT) ? d : TOUT) + 2;
      it.err = 1;
    end
    @(negedge clk);
    useExtClk = ext; oscKeep = keep; shortDelay = sh; pllEn = pe;
    stopReq = 1'b1; pllLock = 1'b0;
    @(negedge clk);
    stopReq = 1'b0;
    check(oscEnable == keep, {tag, " R3 oscEnable in stop"}, int'(oscEnable), int'(keep));
    check(pllEnable == keep, {tag, " R3 pllEnable in stop"}, int'(pllEnable), int'(keep));
    check(lockErr == 1'b0, {tag, " R9 lockErr cleared on stop"}, int'(lockErr), 0);
    // R2: disturb the configuration inputs after entry
    useExtClk = ~ext; oscKeep = ~keep; shortDelay = ~sh; pllEn = ~pe;
    repeat (3) @(negedge clk);
    check(oscEnable == keep, {tag, " R2 enable follows latched keep"}, int'(oscEnable), int'(keep));
    expQ.push_back(it);
    wakeCyc = cyc + 1;
    resumeSeen = 1'b0;
    wakeReq = 1'b1;
    k = 0;
    while (!resumeSeen) begin
      @(negedge clk);
      k++;
      if (!holdWake) wakeReq = 1'b0;
      if (k == 1) begin
        check(oscEnable && pllEnable, {tag, " R3 enables on in recovery"},
              int'(oscEnable && pllEnable), 1);
      end
      if (need && lockAt > 0 && k == lockAt) pllLock = 1'b1;
      if (k > 5000) break;
    end
    wakeReq = 1'b0;
    check(resumeSeen, {tag, " R5 resume reached"}, int'(resumeSeen), 1);
    @(negedge clk);
    check(resumeCore == 1'b0, {tag, " R8 pulse ends"}, int'(resumeCore), 0);
    repeat (3) @(negedge clk);
    check(int'(lockErr) == it.err, {tag, " R9 lockErr held in run"}, int'(lockErr), it.err);
    check(oscEnable && pllEnable, {tag, " R3 enables on in run"}, int'(oscEnable && pllEnable), 1);
  endtask

  task automatic mainSeq();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(oscEnable && pllEnable, "R1 enables after reset", int'(oscEnable && pllEnable), 1);
    check(!resumeCore && !lockErr, "R1 outputs after reset", int'(resumeCore || lockErr), 0);

    // R7: wake in run does nothing
    wakeReq = 1'b1;
    repeat (6) @(negedge clk);
    wakeReq = 1'b0;
    check(oscEnable && pllEnable, "R7 wake in run leaves enables", int'(oscEnable && pllEnable), 1);
    repeat (2) @(negedge clk);

    runCase(0, 0, 0, 0, 0, 0, "R4 int long");
    runCase(0, 0, 1, 0, 0, 0, "R4 int short");
    runCase(0, 1, 1, 1, 0, 0, "R4 int keep ignores short");
    runCase(1, 1, 0, 0, 0, 0, "R4 ext keep no delay");
    runCase(1, 1, 1, 0, 0, 1, "R4 R7 ext keep short wake held");
    runCase(1, 0, 0, 0, 0, 0, "R4 ext long");
    runCase(1, 0, 1, 1, 40, 0, "R5 lock after delay");
    runCase(0, 0, 1, 1, 5, 0, "R5 lock before delay");
    runCase(1, 0, 1, 1, 0, 0, "R6 lock timeout");
    runCase(0, 1, 0, 0, 0, 0, "R9 error clears next stop");

    // R1: reset in the middle of recovery abandons it
    @(negedge clk);
    useExtClk = 0; oscKeep = 0; shortDelay = 0; pllEn = 0; stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0; wakeReq = 1'b1;
    @(negedge clk);
    wakeReq = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(oscEnable && pllEnable, "R1 enables after mid-recovery reset",
          int'(oscEnable && pllEnable), 1);
    repeat (LONG_D + 20) @(negedge clk);
    check(resumeCore == 1'b0, "R1 no resume after reset", int'(resumeCore), 0);
    check(expQ.size() == 0, "R8 every expected resume seen", expQ.size(), 0);
  endtask

  initial begin
    fork
      mainSeq();
      begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 1, 0);
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule